// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is the watchdog of a real-time clock device. Software programs one byte that holds a 5-bit count, a 2-bit scale and a steering bit. The count times four raised to the scale gives the timeout in ticks of a 16 Hz strobe. Every write or read of the byte starts the countdown again. If software does not come back before the countdown ends, the watchdog expires.

On expiry the steering bit selects the action. The block either emits a one-cycle interrupt pulse, or it requests a system reset. When it requests a reset, it also clears its own control byte and sends a one-cycle request to clear the century bit held in the neighbouring day register. In both cases a sticky expiry flag is set. That flag is bit 7 of a separate flags register, and the next arming of the watchdog clears it.

The host reaches the block through one register select with read and write strobes. The 16 Hz tick comes from outside.

Top module: `wdog_steer`

## Requirements
- R1: After reset the control byte reads 0x00, the expiry flag is 0, and the interrupt, reset-request and century-clear outputs are 0.
- R2: The control byte holds the scale S in bits [1:0] and the count C in bits [6:2]. When the watchdog is armed with C nonzero, it expires on exactly the (C × 4^S)-th tick strobe after arming.
- R3: A control byte with C = 0 disables the watchdog. This covers 0x00 and also a byte that has only a nonzero scale. No expiry happens, however many ticks arrive.
- R4: A write with select and write strobe high stores the data byte and restarts the countdown from the new byte's timeout, discarding any ticks already counted.
- R5: A read with select and read strobe high returns the control byte on the read data port and restarts the countdown from the stored byte's timeout.
- R6: Every write or read clears the expiry flag. Expiry sets the flag, and it stays set until the next write or read.
- R7: If bit 7 of the control byte is 1 at expiry, the block raises the reset request and the century-clear output for one cycle each, clears the control byte to 0x00, and does not raise the interrupt.
- R8: If bit 7 of the control byte is 0 at expiry, the block raises the interrupt for exactly one cycle, keeps the control byte unchanged, and does not raise the reset request.
- R9: After expiry the watchdog stays idle and produces no further pulses until it is armed again by a write or read.
- R10: The countdown advances only on cycles where the tick strobe is high. Clock cycles without a tick never cause an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 16 Hz time-base strobe |
| sel | input | 1 | Register select for the control byte |
| wr_en | input | 1 | Write strobe; it wins if it is high together with rd_en |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current control byte |
| irq_pulse | output | 1 | One-cycle interrupt pulse on a non-steered expiry |
| rst_req | output | 1 | One-cycle system reset request on a steered expiry |
| cen_clr | output | 1 | One-cycle request to clear the century bit of the day register |
| wd_flag | output | 1 | Sticky expiry flag, bit 7 of the flags register |

## Verification
The bench builds the block with its default widths: a 5-bit count and a 2-bit scale, giving timeouts of up to 1984 ticks. It drives the tick once every two clock cycles, so the full scale of timeouts can be reached in a short run. It times a largest-scale timeout of 128 ticks tick by tick, as well as the one- to five-tick cases. Restart, disable and steering are each tested partway through a countdown. A separate phase holds the tick low for many cycles to show that bare clock cycles never advance the count.

// File: rtl/wdog_steer.sv
`timescale 1ns/1ps
module wdog_steer #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_pulse,
  output logic       rst_req,
  output logic       cen_clr,
  output logic       wd_flag
);
  localparam int MAX_SH = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W  = MULT_W + MAX_SH;
  localparam int STEER  = RES_W + MULT_W;

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic             acc_wr, acc_any;
  logic [7:0]       arm_val;
  logic [CNT_W-1:0] load_val;

  assign acc_wr   = sel & wr_en;
  assign acc_any  = sel & (wr_en | rd_en);
  assign arm_val  = acc_wr ? wdata : ctrl_q;
  assign load_val = CNT_W'(arm_val[STEER-1:RES_W]) << {arm_val[RES_W-1:0], 1'b0};
  assign rdata    = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      run_q     <= 1'b0;
      wd_flag   <= 1'b0;
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
      cen_clr   <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
      cen_clr   <= 1'b0;
      if (acc_any) begin
        if (acc_wr) ctrl_q <= wdata;
        wd_flag <= 1'b0;
        cnt_q   <= load_val;
        run_q   <= (load_val != '0);
      end else if (run_q && tick) begin
        if (cnt_q == CNT_W'(1)) begin
          run_q   <= 1'b0;
          wd_flag <= 1'b1;
          if (ctrl_q[STEER]) begin
            rst_req <= 1'b1;
            cen_clr <= 1'b1;
            ctrl_q  <= '0;
          end else begin
            irq_pulse <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdog_steer_chk.sv
`timescale 1ns/1ps
module wdog_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       irq_pulse,
  input logic       rst_req,
  input logic       cen_clr,
  input logic       wd_flag
);
  // R8
  irq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R7
  rst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rdata == 8'h00 && cen_clr && !irq_pulse));

  // R6
  expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || rst_req) |-> wd_flag);

  // R6
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (wr_en || rd_en)) |=> !wd_flag);

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !(irq_pulse || rst_req));
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .irq_pulse(irq_pulse), .rst_req(rst_req),
  .cen_clr(cen_clr), .wd_flag(wd_flag)
);

// File: tb/sim_wdog_steer.sv
`timescale 1ns/1ps
module sim_wdog_steer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_pulse, rst_req, cen_clr, wd_flag;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdog_steer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse),
    .rst_req(rst_req), .cen_clr(cen_clr), .wd_flag(wd_flag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); sel = 1; wr_en = 1; wdata = v;
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); sel = 1; rd_en = 1; v = rdata;
    @(negedge clk); sel = 0; rd_en = 0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic quiet_ticks(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      one_tick();
      if (irq_pulse || rst_req || cen_clr) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic expect_expiry(input int t, input bit steer, input logic [7:0] ctrl, input string req);
    quiet_ticks(t - 1, req);
    one_tick();
    check(irq_pulse == !steer, req, irq_pulse, !steer);
    check(rst_req == steer && cen_clr == steer, req, {rst_req, cen_clr}, {steer, steer});
    check(wd_flag == 1'b1, {req, " R6 flag"}, wd_flag, 1);
    check(rdata == (steer ? 8'h00 : ctrl), req, rdata, steer ? 0 : ctrl);
    @(negedge clk);
    check(!irq_pulse && !rst_req && !cen_clr, {req, " single pulse"},
          {irq_pulse, rst_req, cen_clr}, 0);
  endtask

  task automatic t_reset();
    check(rdata == 8'h00, "R1 ctrl", rdata, 0);
    check(!wd_flag && !irq_pulse && !rst_req && !cen_clr, "R1 outputs",
          {wd_flag, irq_pulse, rst_req, cen_clr}, 0);
  endtask

  task automatic t_basic();
    do_write(8'h05);
    check(wd_flag == 0, "R6 arm clears", wd_flag, 0);
    expect_expiry(4, 0, 8'h05, "R8 irq C1S1");
    quiet_ticks(20, "R9 idle after expiry");
    check(wd_flag == 1, "R6 flag holds", wd_flag, 1);
  endtask

  task automatic t_read_rearm();
    logic [7:0] v;
    do_read(v);
    check(v == 8'h05, "R5 read data", v, 8'h05);
    check(wd_flag == 0, "R6 read clears flag", wd_flag, 0);
    expect_expiry(4, 0, 8'h05, "R5 rearm by read");
  endtask

  task automatic t_scales();
    do_write(8'h0B); expect_expiry(128, 0, 8'h0B, "R2 C2S3");
    do_write(8'h7C); expect_expiry(31, 0, 8'h7C, "R2 C31S0");
    do_write(8'h04); expect_expiry(1, 0, 8'h04, "R2 C1S0");
  endtask

  task automatic t_restart();
    logic [7:0] v;
    do_write(8'h10); quiet_ticks(3, "R4 pre");
    do_write(8'h14); expect_expiry(5, 0, 8'h14, "R4 write restart");
    do_write(8'h10); quiet_ticks(3, "R5 pre");
    do_read(v); expect_expiry(4, 0, 8'h10, "R5 read restart");
  endtask

  task automatic t_disable();
    do_write(8'h10); quiet_ticks(2, "R3 pre");
    do_write(8'h00); quiet_ticks(40, "R3 zero stops");
    do_write(8'h03); quiet_ticks(40, "R3 zero count");
    check(rdata == 8'h03, "R3 byte kept", rdata, 8'h03);
  endtask

  task automatic t_steer();
    do_write(8'h88); expect_expiry(2, 1, 8'h88, "R7 reset steer");
    quiet_ticks(10, "R9 idle after reset");
  endtask

  task automatic t_no_tick();
    int bad = 0;
    do_write(8'h04);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq_pulse || rst_req) bad++;
    end
    check(bad == 0, "R10 no tick no expiry", bad, 0);
    one_tick();
    check(irq_pulse == 1, "R10 tick expires", irq_pulse, 1);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_read_rearm();
    t_scales();
    t_restart();
    t_disable();
    t_steer();
    t_no_tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule